// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block is a clocked controller for one phase of a synchronous buck power stage. It takes a single PWM command and produces two gate enables: one for the high-side switch and one for the low-side switch. The PWM command arrives already decoded into three flags: high, low and mid-window. Comparators, supply monitors and gate drivers sit outside the block and reach it only as single-bit inputs.

The block applies four controls.
- A stage-enable gate: the supply-good bit and an active-low disable pin must both be true.
- A mid-level hold-off timer. It shuts the stage down when the PWM input stays parked in its mid window.
- Adaptive break-before-make dead time. A gate may turn on only after the opposite gate reports that it has discharged.
- Optional diode emulation. This cuts the low side when the inductor current reverses, and the decision is made again in every switching cycle.

Hold-off and dead time are both counted in clock cycles. The disable input must be tied or pulled to 0 when it is unconnected, so that an open pin leaves the stage off.

Top module: `hb_gate_seq`

## Requirements
- R1: During reset, and at every clock edge where `supply_ok` is 0 or `dis_n` is 0, both gate outputs become 0 at that edge, whatever the PWM flags say.
- R2: When enabled and settled with both discharge senses at 1, `gate_hs` equals the PWM level and `gate_ls` equals its inverse.
- R3: At the edge where the mid window has been sampled on `HOLD_CYC+1` consecutive edges, both gates go to 0 and stay 0 while the window persists. An excursion of `HOLD_CYC` edges or fewer leaves the gates as they were.
- R4: On leaving the mid window, the new level is followed with no further hold-off. A low level brings up the low side and a high level brings up the high side, each after the dead time of R5 or R6.
- R5: When the command becomes high, `gate_ls` falls at that edge. `gate_hs` rises at the (`DEAD_CYC`+1)th edge at which the command is high, `gate_ls` is 0 and `ls_off_sense` is 1; the count restarts whenever the sense bit is 0.
- R6: When the command becomes low, `gate_hs` falls at that edge. `gate_ls` rises at the (`DEAD_CYC`+1)th edge at which the command is low, `gate_hs` is 0 and `hs_off_sense` is 1.
- R7: `gate_hs` and `gate_ls` are never 1 in the same cycle.
- R8: With `zc_en_n`=0, `gate_ls` is 0 after any edge that samples `il_neg`=1 during a low command. It then stays 0, even after `il_neg` returns to 0, until the command next goes high.
- R9: With `zc_en_n`=1, `il_neg` has no effect, and the low side stays on for the whole low interval.
- R10: The PWM input is decoded as follows. The mid window is `pwm_mid`=1, or `pwm_hi` equal to `pwm_lo`. Otherwise the level is `pwm_hi`. A short mid excursion keeps the last level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | PWM decoded as high |
| pwm_lo | input | 1 | PWM decoded as low |
| pwm_mid | input | 1 | PWM inside mid window |
| dis_n | input | 1 | Active-low stage disable |
| supply_ok | input | 1 | Supply above lockout threshold |
| zc_en_n | input | 1 | Active-low diode-emulation enable |
| ls_off_sense | input | 1 | Low-side gate discharged |
| hs_off_sense | input | 1 | High-side gate-to-phase discharged |
| il_neg | input | 1 | Inductor current negative (low-side drain current positive) |
| gate_hs | output | 1 | High-side gate enable |
| gate_ls | output | 1 | Low-side gate enable |

## Verification
The checker watches several properties on every cycle:
- the two gates never overlap;
- disable or lockout forces both gates off;
- each gate rises only after the opposite gate was off and reported discharged;
- sampled reverse current with emulation active kills the low side;
- a mid-window run longer than the hold-off keeps both gates down.

Some behaviour can be shown only by the directed scenarios:
- the exact edge on which a gate rises after the dead count;
- that a mid excursion of exactly the hold-off length changes nothing;
- that the diode-emulation block is sticky until the next high command and is then released;
- that reverse current is ignored in synchronous mode.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
   typedef enum logic [1:0] {
      CMD_OFF = 2'd0,
      CMD_LS  = 2'd1,
      CMD_HS  = 2'd2
   } hb_cmd_e;

   localparam int SIDE_HS = 0;
   localparam int SIDE_LS = 1;
   localparam int N_SIDES = 2;
endpackage

// File: rtl/hb_mid_holdoff.sv
// Decodes the three PWM flags into a gate command, applies enable gating
// and the mid-window shutdown timer.
module hb_mid_holdoff
   import hb_gate_pkg::*;
#(
   parameter int HOLD_CYC = 16
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pwm_hi,
   input  logic    pwm_lo,
   input  logic    pwm_mid,
   input  logic    stage_en,
   output hb_cmd_e cmd
);
   localparam int HW = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HOLD_MAX = HW'(HOLD_CYC);

   logic          in_mid;
   logic [HW-1:0] mid_cnt;
   logic          last_lvl;
   logic          mid_expired;

   // ambiguous flag pairs are treated as the mid window
   assign in_mid = pwm_mid | (pwm_hi == pwm_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_cnt  <= '0;
         last_lvl <= 1'b0;
      end else begin
         if (!in_mid) begin
            mid_cnt  <= '0;
            last_lvl <= pwm_hi;
         end else if (mid_cnt != HOLD_MAX) begin
            mid_cnt <= mid_cnt + HW'(1);
         end
      end
   end

   assign mid_expired = in_mid && (mid_cnt == HOLD_MAX);

   always_comb begin
      if (!stage_en || mid_expired) begin
         cmd = CMD_OFF;
      end else if (in_mid) begin
         cmd = last_lvl ? CMD_HS : CMD_LS;
      end else begin
         cmd = pwm_hi ? CMD_HS : CMD_LS;
      end
   end
endmodule

// File: rtl/hb_dead_timer.sv
// Counts consecutive edges on which a turn-on is permitted; fires on the
// edge that completes the dead-on delay.
module hb_dead_timer #(
   parameter int DEAD_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   output logic fire
);
   localparam int CW = $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] DEAD_MAX = CW'(DEAD_CYC);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (!arm) begin
         cnt <= '0;
      end else if (cnt != DEAD_MAX) begin
         cnt <= cnt + CW'(1);
      end
   end

   assign fire = arm && (cnt == DEAD_MAX);
endmodule

// File: rtl/hb_zcd_cut.sv
// Diode-emulation cutoff: blocks the low side after reverse current until
// the next high command.
module hb_zcd_cut
   import hb_gate_pkg::*;
#(
   parameter bit ZCD_PRESENT = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    zc_en_n,
   input  logic    il_neg,
   input  hb_cmd_e cmd,
   output logic    ls_cut
);
   generate
      if (ZCD_PRESENT) begin : g_zcd
         logic active;
         logic blocked;

         assign active = ~zc_en_n;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               blocked <= 1'b0;
            end else if (!active || cmd == CMD_HS) begin
               blocked <= 1'b0;
            end else if (cmd == CMD_LS && il_neg) begin
               blocked <= 1'b1;
            end
         end

         assign ls_cut = active && (blocked || il_neg);
      end else begin : g_sync_only
         assign ls_cut = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
   import hb_gate_pkg::*;
#(
   parameter int HOLD_CYC    = 16,
   parameter int DEAD_CYC    = 4,
   parameter bit ZCD_PRESENT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_hi,
   input  logic pwm_lo,
   input  logic pwm_mid,
   input  logic dis_n,
   input  logic supply_ok,
   input  logic zc_en_n,
   input  logic ls_off_sense,
   input  logic hs_off_sense,
   input  logic il_neg,
   output logic gate_hs,
   output logic gate_ls
);
   initial begin
      if (HOLD_CYC < 1) $fatal(1, "hb_gate_seq: HOLD_CYC must be at least 1");
      if (DEAD_CYC < 1) $fatal(1, "hb_gate_seq: DEAD_CYC must be at least 1");
   end

   hb_cmd_e            cmd;
   logic               stage_en;
   logic               ls_cut;
   logic [N_SIDES-1:0] arm;
   logic [N_SIDES-1:0] fire;
   logic               gh_q, gl_q;

   assign stage_en = supply_ok & dis_n;

   hb_mid_holdoff #(.HOLD_CYC(HOLD_CYC)) u_mid (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwm_hi   (pwm_hi),
      .pwm_lo   (pwm_lo),
      .pwm_mid  (pwm_mid),
      .stage_en (stage_en),
      .cmd      (cmd)
   );

   hb_zcd_cut #(.ZCD_PRESENT(ZCD_PRESENT)) u_zcd (
      .clk     (clk),
      .rst_n   (rst_n),
      .zc_en_n (zc_en_n),
      .il_neg  (il_neg),
      .cmd     (cmd),
      .ls_cut  (ls_cut)
   );

   // turn-on permission: own side commanded, opposite gate off and discharged
   assign arm[SIDE_HS] = (cmd == CMD_HS) && !gh_q && !gl_q && ls_off_sense;
   assign arm[SIDE_LS] = (cmd == CMD_LS) && !gl_q && !gh_q && hs_off_sense && !ls_cut;

   generate
      for (genvar s = 0; s < N_SIDES; s++) begin : g_side
         hb_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .arm   (arm[s]),
            .fire  (fire[s])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gh_q <= 1'b0;
         gl_q <= 1'b0;
      end else begin
         gh_q <= (cmd == CMD_HS) && (gh_q || fire[SIDE_HS]);
         gl_q <= (cmd == CMD_LS) && !ls_cut && (gl_q || fire[SIDE_LS]);
      end
   end

   assign gate_hs = gh_q;
   assign gate_ls = gl_q;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
   parameter int HOLD_CYC = 16
) (
   input logic clk,
   input logic rst_n,
   input logic pwm_hi,
   input logic pwm_lo,
   input logic pwm_mid,
   input logic dis_n,
   input logic supply_ok,
   input logic zc_en_n,
   input logic ls_off_sense,
   input logic hs_off_sense,
   input logic il_neg,
   input logic gate_hs,
   input logic gate_ls
);
   localparam int RW = $clog2(HOLD_CYC + 2) + 1;
   localparam logic [RW-1:0] RUN_LIM = RW'(HOLD_CYC + 1);

   logic [RW-1:0] mid_run;
   logic          mid_seen;

   assign mid_seen = pwm_mid || (pwm_hi == pwm_lo);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mid_run <= '0;
      else if (!mid_seen) mid_run <= '0;
      else if (mid_run != RUN_LIM) mid_run <= mid_run + RW'(1);
   end

   p_gates_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(supply_ok && dis_n) |=> (!gate_hs && !gate_ls));

   p_hs_needs_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hs) |-> ($past(supply_ok) && $past(dis_n)));

   p_mid_shutdown_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mid_run == RUN_LIM) |-> (!gate_hs && !gate_ls));

   p_hs_after_ls_dis_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hs) |-> ($past(ls_off_sense) && !$past(gate_ls)));

   p_ls_after_hs_dis_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_ls) |-> ($past(hs_off_sense) && !$past(gate_hs)));

   p_no_overlap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hs && gate_ls));

   p_zcd_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!zc_en_n && il_neg) |=> !gate_ls);
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwm_hi       (pwm_hi),
   .pwm_lo       (pwm_lo),
   .pwm_mid      (pwm_mid),
   .dis_n        (dis_n),
   .supply_ok    (supply_ok),
   .zc_en_n      (zc_en_n),
   .ls_off_sense (ls_off_sense),
   .hs_off_sense (hs_off_sense),
   .il_neg       (il_neg),
   .gate_hs      (gate_hs),
   .gate_ls      (gate_ls)
);

// File: tb/test_hb_gate_seq.sv
`timescale 1ns/1ps
module test_hb_gate_seq;
   localparam int CLK_PERIOD = 10;
   localparam int HOLD = 16;
   localparam int DEAD = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwm_hi = 1'b0, pwm_lo = 1'b1, pwm_mid = 1'b0;
   logic dis_n = 1'b1, supply_ok = 1'b1, zc_en_n = 1'b1;
   logic ls_off_sense = 1'b1, hs_off_sense = 1'b1, il_neg = 1'b0;
   logic gate_hs, gate_ls;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hb_gate_seq #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD), .ZCD_PRESENT(1'b1)) i_hb_gate_seq (
      .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .pwm_mid(pwm_mid),
      .dis_n(dis_n), .supply_ok(supply_ok), .zc_en_n(zc_en_n),
      .ls_off_sense(ls_off_sense), .hs_off_sense(hs_off_sense), .il_neg(il_neg),
      .gate_hs(gate_hs), .gate_ls(gate_ls)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic chk(input string req, input logic [1:0] exp);
      n_cmp++;
      if ({gate_hs, gate_ls} !== exp) begin
         n_bad++;
         $display("FAIL %s: gh/gl got %b expected %b at %0t", req, {gate_hs, gate_ls}, exp, $time);
      end
   endtask

   task automatic set_high();
      pwm_hi = 1'b1; pwm_lo = 1'b0; pwm_mid = 1'b0;
   endtask

   task automatic set_low();
      pwm_hi = 1'b0; pwm_lo = 1'b1; pwm_mid = 1'b0;
   endtask

   // R7: overlap monitor on every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (gate_hs && gate_ls) begin
            n_bad++;
            $display("FAIL R7: overlap got 11 expected not 11 at %0t", $time);
         end
      end
   end

   task automatic t_reset();
      tick(3);
      chk("R1 reset", 2'b00);
      rst_n = 1'b1;
      tick(DEAD);
      chk("R6 first low wait", 2'b00);
      tick();
      chk("R2/R6 low side up", 2'b01);
   endtask

   task automatic t_rise();
      set_high();
      tick();
      chk("R5 low side off first", 2'b00);
      tick(DEAD);
      chk("R5 dead time", 2'b00);
      tick();
      chk("R2/R5 high side up", 2'b10);
   endtask

   task automatic t_fall();
      set_low();
      tick();
      chk("R6 high side off first", 2'b00);
      tick(DEAD);
      chk("R6 dead time", 2'b00);
      tick();
      chk("R2/R6 low side up", 2'b01);
   endtask

   task automatic t_rise_sense_wait();
      ls_off_sense = 1'b0;
      set_high();
      tick(7);
      chk("R5 waits for low sense", 2'b00);
      ls_off_sense = 1'b1;
      tick(DEAD);
      chk("R5 dead after sense", 2'b00);
      tick();
      chk("R5 high after sense", 2'b10);
   endtask

   task automatic t_fall_sense_wait();
      hs_off_sense = 1'b0;
      set_low();
      tick(7);
      chk("R6 waits for high sense", 2'b00);
      hs_off_sense = 1'b1;
      tick(DEAD);
      chk("R6 dead after sense", 2'b00);
      tick();
      chk("R6 low after sense", 2'b01);
   endtask

   task automatic t_mid();
      pwm_mid = 1'b1;
      tick(HOLD);
      chk("R3 short mid holds", 2'b01);
      set_low();
      tick();
      chk("R3 short mid no shutdown", 2'b01);
      pwm_mid = 1'b1;
      tick(HOLD);
      chk("R3 before expiry", 2'b01);
      tick();
      chk("R3 shutdown", 2'b00);
      tick(5);
      chk("R3 stays off", 2'b00);
      set_high();
      tick(DEAD);
      chk("R4 exit high dead", 2'b00);
      tick();
      chk("R4 exit high", 2'b10);
      pwm_mid = 1'b1;
      tick(HOLD);
      chk("R3 high held", 2'b10);
      tick();
      chk("R3 high shutdown", 2'b00);
      set_low();
      tick(DEAD);
      chk("R4 exit low dead", 2'b00);
      tick();
      chk("R4 exit low", 2'b01);
   endtask

   task automatic t_ambiguous();
      pwm_hi = 1'b1; pwm_lo = 1'b1; pwm_mid = 1'b0;
      tick(HOLD);
      chk("R10 ambiguous held as mid", 2'b01);
      tick();
      chk("R10 ambiguous shutdown", 2'b00);
      set_low();
      tick(DEAD + 1);
      chk("R10 recover", 2'b01);
   endtask

   task automatic t_disable();
      set_high();
      tick(DEAD + 3);
      chk("R2 high steady", 2'b10);
      dis_n = 1'b0;
      tick();
      chk("R1 disable", 2'b00);
      dis_n = 1'b1;
      tick(DEAD);
      chk("R1 re-enable wait", 2'b00);
      tick();
      chk("R1 re-enable", 2'b10);
      supply_ok = 1'b0;
      tick();
      chk("R1 lockout", 2'b00);
      tick(3);
      chk("R1 lockout held", 2'b00);
      supply_ok = 1'b1;
      set_low();
      tick(DEAD + 2);
      chk("R1 low after lockout", 2'b01);
   endtask

   task automatic t_zcd();
      zc_en_n = 1'b0;
      tick();
      chk("R8 low on positive current", 2'b01);
      il_neg = 1'b1;
      tick();
      chk("R8 cut", 2'b00);
      il_neg = 1'b0;
      tick(4);
      chk("R8 sticky", 2'b00);
      set_high();
      tick(DEAD);
      chk("R8 high dead", 2'b00);
      tick();
      chk("R8 high", 2'b10);
      il_neg = 1'b1;
      set_low();
      tick(DEAD + 4);
      chk("R8 never on with negative current", 2'b00);
      il_neg = 1'b0;
      tick(2);
      chk("R8 stays blocked", 2'b00);
      set_high();
      tick(DEAD + 1);
      chk("R8 next cycle high", 2'b10);
      set_low();
      tick(DEAD + 2);
      chk("R8 released next cycle", 2'b01);
   endtask

   task automatic t_sync();
      zc_en_n = 1'b1;
      il_neg = 1'b1;
      tick(5);
      chk("R9 reverse current ignored", 2'b01);
      il_neg = 1'b0;
      tick();
      chk("R9 still on", 2'b01);
   endtask

   initial begin
      t_reset();
      t_rise();
      t_fall();
      t_rise_sense_wait();
      t_fall_sense_wait();
      t_mid();
      t_ambiguous();
      t_disable();
      t_zcd();
      t_sync();
      tick(2);
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule